// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

The block is a binary up-counter built from identical narrow stages, by default four stages of four bits each for a 16-bit count. Each stage can be cleared, preset from a parallel word or advanced, and every action takes effect on the rising clock edge. The stages share the clock, the clear input, the preset input and the free-running count enable. Each stage also has a chain enable. It takes that enable from the carry of the stage below it, so a stage advances only on the edge where every lower stage rolls over.

Control follows a fixed priority. Clear wins over preset, preset wins over counting, and counting needs both enables. In every other case the count holds. The carry output of the top stage is exposed so that a further copy of the block can be chained above this one. The carry is combinational and is gated by the chain enable.

Top module: `casc_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge, `count` becomes 0 after that edge, whatever `load_n`, `cnt_en`, `chain_en` and `load_val` are.
- R2: When `rst_n` is high and `load_n` is low at a rising edge, `count` takes the value of `load_val` bit for bit, whatever the enables are.
- R3: When `rst_n` and `load_n` are high and both `cnt_en` and `chain_en` are high, `count` increases by one at the edge.
- R4: When `rst_n` and `load_n` are high and `cnt_en` is low, `count` holds its value, whatever `chain_en` is.
- R5: When `chain_en` is low, `count` holds its value (unless clear or preset applies), and `carry_out` is low in the same cycle.
- R6: `carry_out` is high exactly when `chain_en` is high and `count` is all ones. It follows those inputs combinationally, with no clock delay.
- R7: On an increment from all ones (0xFFFF at default width), `count` wraps to 0.
- R8: A stage advances only on an edge where every stage below it holds all ones (bits [4k-1:0] all ones for stage k). Lower-stage rollovers therefore carry into upper stages on the same edge, and the full word behaves as one wide binary counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all actions on rising edge |
| rst_n | input | 1 | Synchronous active-low clear of the whole count |
| load_n | input | 1 | Synchronous active-low preset from `load_val` |
| cnt_en | input | 1 | Count enable shared by all stages |
| chain_en | input | 1 | Chain enable into the lowest stage; gates counting and carry |
| load_val | input | 16 | Parallel preset word |
| count | output | 16 | Current count, stage k in bits [4k+3:4k] |
| carry_out | output | 1 | Terminal carry of the top stage, for chaining a further block |

## Verification
Clear, preset, increment and hold take effect at the rising edge where the controls are sampled. Their effect is visible on `count` one edge later. `carry_out` has no register and reflects `count` and `chain_en` within the same cycle. The bench drives every input at a falling edge. Before the next rising edge it checks `carry_out` against the model's current count. It then checks `count` at the following falling edge against the model's next value, so each result is sampled half a period after it is due.

// File: rtl/casc_counter_pkg.sv
// Package: shared action type for the counter stages.
// Assumes: one action is chosen per stage per clock edge.
package casc_counter_pkg;

    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_INC   = 2'd2,
        ACT_HOLD  = 2'd3
    } ctr_act_e;

endpackage

// File: rtl/ctr_mode_dec.sv
// Module: ctr_mode_dec
// Picks the action of one stage from its control inputs with the fixed
// priority clear > preset > count > hold.
// Assumes: all control inputs are synchronous to the stage clock.
module ctr_mode_dec
    import casc_counter_pkg::*;
(
    input  logic     clr_n,
    input  logic     ld_n,
    input  logic     en_p,
    input  logic     en_t,
    output ctr_act_e act
);

    // Priority decode of the four stage actions.
    always_comb begin
        if (!clr_n)
            act = ACT_CLEAR;
        else if (!ld_n)
            act = ACT_LOAD;
        else if (en_p && en_t)
            act = ACT_INC;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/ctr_stage.sv
// Module: ctr_stage
// One W-bit up-counter stage with synchronous clear, preset and two
// enables. Its terminal carry is high when the chain enable is high and
// the stage holds all ones.
// Assumes: the chain enable comes from the carry of the stage below, or
// from the block input for the lowest stage.
module ctr_stage
    import casc_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    ctr_act_e act;

    ctr_mode_dec u_dec (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .act   (act)
    );

    // State register: applies the decoded action on each rising edge.
    always_ff @(posedge clk) begin
        case (act)
            ACT_CLEAR: q <= '0;
            ACT_LOAD:  q <= d;
            ACT_INC:   q <= q + ONE;
            default:   q <= q;
        endcase
    end

    // Terminal carry, gated by the chain enable for cascading.
    always_comb tc = en_t && (q == ALL_ONES);

    // R1: a clear leaves the stage at zero on the next cycle.
    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!clr_n)
        $past(!clr_n) |-> (q == '0));

    // R2: a preset copies the data word.
    p_load_copy_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (!ld_n) |=> (q == $past(d)));

    // R3: both enables advance the stage by one.
    p_inc_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_p && en_t) |=> (q == $past(q) + ONE));

    // R4: without both enables the stage holds.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/casc_counter.sv
// Module: casc_counter
// Chains STAGES identical counter stages into one wide synchronous
// counter. Each stage's carry feeds the chain enable of the next stage,
// and the top carry is exposed for further chaining.
// Assumes: one clock for all stages; controls are synchronous.
module casc_counter #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 4,
    parameter int TOT_W   = STAGE_W * STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [TOT_W-1:0] load_val,
    output logic [TOT_W-1:0] count,
    output logic             carry_out
);

    localparam logic [TOT_W-1:0] ONE_W = {{(TOT_W-1){1'b0}}, 1'b1};

    logic [STAGES:0] chain;

    // Chain input of the lowest stage comes from the block input.
    always_comb chain[0] = chain_en;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        ctr_stage #(
            .W (STAGE_W)
        ) u_stage (
            .clk   (clk),
            .clr_n (rst_n),
            .ld_n  (load_n),
            .en_p  (cnt_en),
            .en_t  (chain[k]),
            .d     (load_val[k*STAGE_W +: STAGE_W]),
            .q     (count[k*STAGE_W +: STAGE_W]),
            .tc    (chain[k+1])
        );
    end

    // Top carry goes out for a further block.
    always_comb carry_out = chain[STAGES];

    // R5: a low chain enable blocks the carry through every stage.
    p_chain_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_en) |-> (!carry_out));

    // R8: with both enables the whole word steps as one counter.
    p_wide_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en && chain_en) |=> (count == $past(count) + ONE_W));

    // R6: a high carry means the full word is all ones.
    p_carry_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (&count));

endmodule

// File: tb/casc_counter_tb_top.sv
// Bench for casc_counter: directed corner cases and seeded random
// control sequences, checked against a bench-side model.
module casc_counter_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic         chain_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         carry_out;

    int           n_tests = 0;
    int           n_fail = 0;
    logic [W-1:0] model = '0;
    bit           done = 1'b0;

    casc_counter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .cnt_en    (cnt_en),
        .chain_en  (chain_en),
        .load_val  (load_val),
        .count     (count),
        .carry_out (carry_out)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic r, logic l,
                                              logic p, logic t, logic [W-1:0] d);
        if (!r)       return '0;
        else if (!l)  return d;
        else if (p && t) return cur + 16'd1;
        else          return cur;
    endfunction

    function automatic logic exp_carry(logic [W-1:0] cur, logic t);
        return t && (cur == 16'hFFFF);
    endfunction

    function automatic string tag_of(logic r, logic l, logic p, logic t, logic [W-1:0] cur);
        if (!r) return "R1";
        if (!l) return "R2";
        if (!p) return "R4";
        if (!t) return "R5";
        if (cur == 16'hFFFF) return "R7";
        if (cur[3:0] == 4'hF) return "R8";
        return "R3";
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check carry, then check count.
    task automatic step(logic r, logic l, logic p, logic t, logic [W-1:0] d);
        string tg;
        rst_n = r; load_n = l; cnt_en = p; chain_en = t; load_val = d;
        tg = tag_of(r, l, p, t, model);
        #1;
        check(t ? "R6" : "R5", {15'd0, carry_out}, {15'd0, exp_carry(model, t)});
        @(posedge clk);
        model = next_val(model, r, l, p, t, d);
        @(negedge clk);
        check(tg, count, model);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        @(negedge clk);
        // R1: clear with all other controls active
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'hABCD);
        check("R1", count, 16'h0000);
        // R2: preset with enables low
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFE);
        check("R2", count, 16'hFFFE);
        // R3: single increment to all ones
        step(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000);
        // R6: carry at all ones with chain_en high, R5 low with chain_en low
        step(1'b1, 1'b1, 1'b1, 1'b0, 16'h0000);
        check("R5", count, 16'hFFFF);
        // R4: hold with cnt_en low and chain_en high
        step(1'b1, 1'b1, 1'b0, 1'b1, 16'h0000);
        // R7: wrap from all ones
        step(1'b1, 1'b1, 1'b1, 1'b1, 16'h1234);
        check("R7", count, 16'h0000);
        // R8: lower stage rollover carries into the stages above
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0FFF);
        step(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000);
        check("R8", count, 16'h1000);
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h12EF);
        step(1'b1, 1'b1, 1'b1, 1'b1, 16'h0000);
        check("R8", count, 16'h12F0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic r, l, p, t;
            logic [W-1:0] d;
            r = ($urandom % 40) != 0;
            l = ($urandom % 12) != 0;
            p = ($urandom % 8) != 0;
            t = ($urandom % 8) != 0;
            d = ($urandom % 3 == 0) ? (16'hFFF0 | 16'($urandom % 16))
                                    : 16'($urandom);
            step(r, l, p, t, d);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule